// File: doc/BRIEF.md
# Byte-Lane Data Memory Access Unit

This block serves load and store requests from a 16-bit core against a small data RAM that is byte addressed. The RAM is built as two byte-wide lanes. Both lanes see the same word index and each has its own write enable. An even byte address selects the low lane and an odd byte address selects the high lane. A word access uses both lanes together.

Each request carries a 16-bit byte address, a size flag, read and write strobes, and write data. A read returns its result one clock later. A byte read is placed on the low 8 bits of the read bus with the upper 8 bits cleared. An address at or above the implemented RAM size reads as zero, and this includes every address with bit 15 set. A word access at an odd address is an alignment fault. The block then pulses a trap output. A faulting store leaves the RAM unchanged, while a faulting load still returns data.

Top module: `bytelane_mem_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `rd_data` is 0x0000, and `rd_valid` and `addr_trap` are 0.
- R2: An aligned word write followed by an aligned word read at the same address returns the written word. `rd_valid` is high for exactly the one cycle that follows the read strobe.
- R3: A byte read returns the byte selected by address bit 0 on `rd_data[7:0]`. Bit 0 = 0 selects the low byte and bit 0 = 1 selects the high byte. `rd_data[15:8]` is zero. This also holds at the top byte of the RAM.
- R4: A byte write (`acc_byte` = 1) stores `acc_wdata[7:0]` into the lane chosen by address bit 0 only. The other lane of that word and `acc_wdata[15:8]` have no effect.
- R5: An address with bit 15 set, or an address at or above `RAM_BYTES`, reads as 0x0000. A write to such an address changes no RAM location.
- R6: A word access (`acc_byte` = 0) with address bit 0 set and either strobe high raises `addr_trap` for exactly one cycle. The pulse comes in the cycle after the access. No other access raises it.
- R7: A misaligned word write modifies no RAM location.
- R8: A misaligned word read still completes. `rd_valid` is raised and the data is the word at the address with bit 0 cleared, or zero if that word is not implemented. The trap pulse comes in the same cycle.
- R9: Byte accesses at odd addresses never trap, and they read and write the high lane.
- R10: When `acc_rd` and `acc_wr` are high together, only the write is performed and `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 16 | Byte address of the access |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe (has priority over read) |
| acc_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rd_data | output | 16 | Read result, low-aligned, held between reads |
| rd_valid | output | 1 | Read result presented this cycle |
| addr_trap | output | 1 | One-cycle alignment-fault pulse |

## Verification
A misaligned word read raises the fault and delivers read data in the same output cycle. The bench issues word reads at odd addresses inside the RAM and in the reserved upper window. In the cycle after each such read it expects `addr_trap` and `rd_valid` to be high together, with the data equal to the aligned word in the RAM case and zero in the reserved case. A misaligned write is driven right after a known word is stored at the even address, and the bench then reads that word back to show the store was dropped. A simultaneous read and write is checked by confirming that no read result appears and that the written value can be read back afterwards.

// File: rtl/blmu_pkg.sv
package blmu_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int LANES  = 2;

  typedef logic [LANES-1:0] lane_mask_t;

  // Word access at an odd byte address
  function automatic logic is_misaligned(logic bsz, logic [ADDR_W-1:0] a);
    return !bsz && a[0];
  endfunction

  // Address falls inside the implemented RAM
  function automatic logic in_ram(logic [ADDR_W-1:0] a, int unsigned lim);
    return !a[ADDR_W-1] && (32'(a) < lim);
  endfunction

  // Lane write enables for a write that has been accepted
  function automatic lane_mask_t lane_mask(logic bsz, logic lsb);
    if (!bsz) return '1;
    return lsb ? lane_mask_t'(2'b10) : lane_mask_t'(2'b01);
  endfunction

  // Shape a fetched word into the read-bus value
  function automatic logic [DATA_W-1:0] shape_read(logic [DATA_W-1:0] w,
                                                  logic bsz, logic lsb,
                                                  logic hit);
    if (!hit) return '0;
    if (!bsz) return w;
    return {8'h00, (lsb ? w[15:8] : w[7:0])};
  endfunction
endpackage

// File: rtl/blmu_decode.sv
module blmu_decode
  import blmu_pkg::*;
#(
  parameter int RAM_BYTES = 2048,
  localparam int WORDS    = RAM_BYTES / 2,
  localparam int IDX_W    = $clog2(WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bsz,
  input  logic              rd,
  input  logic              wr,
  output logic [IDX_W-1:0]  widx,
  output lane_mask_t        we,
  output logic              hit,
  output logic              sel_hi,
  output logic              do_rd,
  output logic              fault
);
  always_comb begin
    widx   = addr[IDX_W:1];
    hit    = in_ram(addr, RAM_BYTES);
    sel_hi = addr[0];
    fault  = (rd || wr) && is_misaligned(bsz, addr);
    do_rd  = rd && !wr;
    we     = '0;
    if (wr && hit && !fault) we = lane_mask(bsz, addr[0]);
  end
endmodule

// File: rtl/blmu_lane.sv
module blmu_lane #(
  parameter int WORDS = 1024,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);
  logic [7:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wbyte;
  end

  assign rbyte = mem[idx];
endmodule

// File: rtl/blmu_align.sv
module blmu_align
  import blmu_pkg::*;
(
  input  logic [DATA_W-1:0] word_in,
  input  logic              bsz,
  input  logic              sel_hi,
  input  logic              hit,
  output logic [DATA_W-1:0] data_out
);
  assign data_out = shape_read(word_in, bsz, sel_hi, hit);
endmodule

// File: rtl/bytelane_mem_unit.sv
module bytelane_mem_unit
  import blmu_pkg::*;
#(
  parameter int RAM_BYTES = 2048,
  localparam int WORDS    = RAM_BYTES / 2,
  localparam int IDX_W    = $clog2(WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] acc_addr,
  input  logic        acc_byte,
  input  logic        acc_rd,
  input  logic        acc_wr,
  input  logic [15:0] acc_wdata,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  output logic        addr_trap
);
  logic [IDX_W-1:0]  widx;
  lane_mask_t        lane_we;
  logic              hit, sel_hi, do_rd, trap_evt;
  logic [7:0]        lane_wd [LANES];
  logic [7:0]        lane_rd [LANES];
  logic [DATA_W-1:0] fetched, shaped;

  blmu_decode #(.RAM_BYTES(RAM_BYTES)) u_dec (
    .addr(acc_addr), .bsz(acc_byte), .rd(acc_rd), .wr(acc_wr),
    .widx(widx), .we(lane_we), .hit(hit), .sel_hi(sel_hi),
    .do_rd(do_rd), .fault(trap_evt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // byte writes always carry their data on the low byte of the bus
    assign lane_wd[g] = acc_byte ? acc_wdata[7:0] : acc_wdata[8*g +: 8];
    blmu_lane #(.WORDS(WORDS)) u_lane (
      .clk(clk), .we(lane_we[g]), .idx(widx),
      .wbyte(lane_wd[g]), .rbyte(lane_rd[g])
    );
    assign fetched[8*g +: 8] = lane_rd[g];
  end

  blmu_align u_align (
    .word_in(fetched), .bsz(acc_byte), .sel_hi(sel_hi),
    .hit(hit), .data_out(shaped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      addr_trap <= 1'b0;
    end else begin
      rd_valid  <= do_rd;
      addr_trap <= trap_evt;
      if (do_rd) rd_data <= shaped;
    end
  end
endmodule

// File: rtl/blmu_chk.sv
module blmu_chk #(
  parameter int RAM_BYTES = 2048
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] acc_addr,
  input logic        acc_byte,
  input logic        acc_rd,
  input logic        acc_wr,
  input logic [15:0] rd_data,
  input logic        rd_valid,
  input logic        addr_trap,
  input logic [1:0]  lane_we,
  input logic        trap_evt
);
  logic odd_word, unmapped;
  assign odd_word = (acc_rd || acc_wr) && !acc_byte && acc_addr[0];
  assign unmapped = acc_addr[15] || (32'(acc_addr) >= RAM_BYTES);

  // R6
  trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    odd_word |=> addr_trap);

  // R6
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_trap && $past(rst_n)) |-> $past(trap_evt));

  // R7
  bad_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !acc_byte && acc_addr[0]) |-> (lane_we == 2'b00));

  // R4
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_byte && !unmapped) |-> (lane_we == (acc_addr[0] ? 2'b10 : 2'b01)));

  // R3
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rst_n) && $past(acc_byte)) |-> (rd_data[15:8] == 8'h00));

  // R5
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rst_n) && $past(unmapped)) |-> (rd_data == 16'h0000));

  // R5
  no_unmapped_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && unmapped) |-> (lane_we == 2'b00));

  // R8
  read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_wr) |=> rd_valid);

  // R10
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_wr) |=> !rd_valid);
endmodule

bind bytelane_mem_unit blmu_chk #(.RAM_BYTES(RAM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_byte(acc_byte),
  .acc_rd(acc_rd), .acc_wr(acc_wr), .rd_data(rd_data), .rd_valid(rd_valid),
  .addr_trap(addr_trap), .lane_we(lane_we), .trap_evt(trap_evt)
);

// File: tb/sim_bytelane_mem_unit.sv
`timescale 1ns/1ps
module sim_bytelane_mem_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_byte = 1'b0, acc_rd = 1'b0, acc_wr = 1'b0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] rd_data;
  logic        rd_valid, addr_trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bytelane_mem_unit u0 (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_byte(acc_byte),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .addr_trap(addr_trap)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        bsz;
    logic [15:0] addr;
    logic [15:0] wd;
    logic [15:0] exp;
    logic        val;
    logic        trp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,16'h0000,16'h1111,16'h0000,0,0,4'd2},  // R2 setup
    '{1,0,0,16'h0010,16'hA1B2,16'h0000,0,0,4'd2},  // R2
    '{0,1,0,16'h0010,16'h0000,16'hA1B2,1,0,4'd2},  // R2
    '{0,1,1,16'h0010,16'h0000,16'h00B2,1,0,4'd3},  // R3 even -> low
    '{0,1,1,16'h0011,16'h0000,16'h00A1,1,0,4'd3},  // R3 odd -> high
    '{1,0,1,16'h0011,16'h005C,16'h0000,0,0,4'd4},  // R4
    '{0,1,0,16'h0010,16'h0000,16'h5CB2,1,0,4'd4},  // R4
    '{1,0,1,16'h0010,16'h3377,16'h0000,0,0,4'd4},  // R4 upper data ignored
    '{0,1,0,16'h0010,16'h0000,16'h5C77,1,0,4'd4},  // R4
    '{1,0,0,16'h0020,16'hBEEF,16'h0000,0,0,4'd7},  // R7 setup
    '{1,0,0,16'h0021,16'h1234,16'h0000,0,1,4'd6},  // R6 R7 misaligned store
    '{0,0,0,16'h0000,16'h0000,16'h0000,0,0,4'd6},  // R6 pulse ends
    '{0,1,0,16'h0020,16'h0000,16'hBEEF,1,0,4'd7},  // R7 unchanged
    '{0,1,0,16'h0021,16'h0000,16'hBEEF,1,1,4'd8},  // R8 read completes
    '{0,1,1,16'h0021,16'h0000,16'h00BE,1,0,4'd9},  // R9
    '{1,0,1,16'h0021,16'h0055,16'h0000,0,0,4'd9},  // R9
    '{0,1,0,16'h0020,16'h0000,16'h55EF,1,0,4'd9},  // R9
    '{1,0,0,16'h0800,16'hFFFF,16'h0000,0,0,4'd5},  // R5
    '{0,1,0,16'h0800,16'h0000,16'h0000,1,0,4'd5},  // R5
    '{0,1,0,16'h0000,16'h0000,16'h1111,1,0,4'd5},  // R5 no alias
    '{0,1,0,16'h8010,16'h0000,16'h0000,1,0,4'd5},  // R5 bit 15 window
    '{1,0,0,16'h07FE,16'h9A3C,16'h0000,0,0,4'd3},  // R3 top word
    '{0,1,1,16'h07FF,16'h0000,16'h009A,1,0,4'd3},  // R3
    '{1,1,0,16'h0030,16'h4242,16'h0000,0,0,4'd10}, // R10
    '{0,1,0,16'h0030,16'h0000,16'h4242,1,0,4'd10}, // R10
    '{0,1,0,16'h8001,16'h0000,16'h0000,1,1,4'd8},  // R8 unmapped fault
    '{1,0,0,16'h8010,16'h7777,16'h0000,0,0,4'd5},  // R5
    '{0,1,0,16'h0010,16'h0000,16'h5C77,1,0,4'd5}   // R5
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic r, input logic b,
                       input logic [15:0] a, input logic [15:0] d);
    acc_wr = w; acc_rd = r; acc_byte = b; acc_addr = a; acc_wdata = d;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "rd_data", rd_data, 16'h0000);
    check("R1", "rd_valid", 16'(rd_valid), 16'h0);
    check("R1", "addr_trap", 16'(addr_trap), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rd_valid after release", 16'(rd_valid), 16'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wr, VEC[i].rd, VEC[i].bsz, VEC[i].addr, VEC[i].wd);
      @(negedge clk);
      drive(0, 0, 0, 16'h0, 16'h0);
      begin
        string tag;
        tag = $sformatf("R%0d", VEC[i].req);
        check(tag, $sformatf("vec %0d trap", i), 16'(addr_trap), 16'(VEC[i].trp));
        check(tag, $sformatf("vec %0d valid", i), 16'(rd_valid), 16'(VEC[i].val));
        if (VEC[i].val) check(tag, $sformatf("vec %0d data", i), rd_data, VEC[i].exp);
      end
    end

    // R6: back-to-back misaligned reads keep trap high each cycle
    drive(0, 1, 0, 16'h0011, 16'h0);
    @(negedge clk);
    check("R6", "first trap", 16'(addr_trap), 16'h1);
    drive(0, 1, 0, 16'h0013, 16'h0);
    @(negedge clk);
    check("R6", "second trap", 16'(addr_trap), 16'h1);
    drive(0, 0, 0, 16'h0, 16'h0);
    @(negedge clk);
    check("R6", "trap cleared", 16'(addr_trap), 16'h0);
    check("R2", "valid single cycle", 16'(rd_valid), 16'h0);

    // R1: reset mid-run while a faulting read is presented
    drive(0, 1, 0, 16'h0021, 16'h0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "rd_data in reset", rd_data, 16'h0000);
    check("R1", "trap in reset", 16'(addr_trap), 16'h0);
    check("R1", "valid in reset", 16'(rd_valid), 16'h0);
    drive(0, 0, 0, 16'h0, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule